// File: doc/BRIEF.md
# I2C Master Stop Condition Generator

This block puts a Stop condition on an I2C bus on behalf of a bus master. Once the acknowledge clock of the last byte has ended and SCL is held low, the controller pulses a request. The generator then pulls SDA low, lets SCL rise, and lets SDA rise while SCL is high. That low-to-high edge on SDA is the Stop condition. Every phase lasts a whole number of bit-timing periods, and each period is marked by a one-cycle baud tick.

The generator drives the two lines as open-drain outputs. An enable of 1 pulls the line low and an enable of 0 releases it. It reads the real line levels back through two-flop synchronisers. If another device holds SCL low after release, the generator waits until SCL is high before it times the high phase. It times the final period only once SDA is seen high. A busy bit shows that a sequence is running and drops by itself when the sequence ends. In that same cycle a sticky stop-seen bit is set and a one-cycle interrupt pulse is given. A collision detector can cancel the sequence through an abort input.

Top module: `i2c_stop_gen`

## Requirements
- R1: A synchronous reset puts the block in idle: both line enables 0, busy 0, stop_seen 0, irq 0.
- R2: A stop_req pulse while idle makes, in the next cycle, busy 1 with both enables 1 (both lines pulled low) and clears stop_seen.
- R3: SDA stays pulled low and SCL stays held low until the first baud tick after the sequence began. That tick releases SCL while SDA stays pulled low.
- R4: After SCL is released, SDA stays pulled low for as long as the synchronised SCL level is low, whatever ticks arrive. If SCL is seen low again during the high phase, that phase starts over.
- R5: One baud tick after SCL is seen high, SDA is released.
- R6: One baud tick after the released SDA is seen high, the sequence ends. In the same cycle busy falls, stop_seen goes to 1 and irq is 1. irq is 0 in the following cycle.
- R7: abort while busy returns the block to idle in the next cycle. Both lines are released, busy falls, irq stays 0 and stop_seen stays 0.
- R8: stop_req while busy has no effect on the running sequence. abort while idle has no effect, and stop_seen keeps its value.
- R9: Line levels reach the sequencer through two synchronising flops. A tick in the first cycle after a released line goes high is not counted as the period that follows that line's rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle request to start a Stop sequence |
| baud_tick | input | 1 | One-cycle strobe marking one bit-timing period |
| abort | input | 1 | Cancel request from a collision detector |
| scl_in | input | 1 | SCL level read from the bus |
| sda_in | input | 1 | SDA level read from the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence running; drops by itself at the end |
| stop_seen | output | 1 | Set when a Stop sequence completes, cleared by the next request |
| irq | output | 1 | One-cycle pulse at completion |

## Verification
The assertions assume that stop_req and abort are single-cycle strobes and that the bus always reads back the level the block itself drives, except where another device holds SCL low. The stimulus models the bus as a wired-AND of the block's enables and an optional SCL hold from the bench. Random gaps, stretch lengths and abort points are drawn with a fixed seed. Ticks are kept out of the window in which a line's new level is still passing through the synchronisers, except for the directed checks that aim at that window.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,   // SCL held low, SDA pulled low
        PH_RISE = 3'd2,   // SCL released, waiting to see it high
        PH_HIGH = 3'd3,   // SCL high, timing one period before SDA rises
        PH_FREE = 3'd4    // SDA released, timing final period
    } stop_phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    function automatic line_drive_t phase_drive(input stop_phase_e ph);
        line_drive_t d;
        case (ph)
            PH_HOLD: d = '{scl_low: 1'b1, sda_low: 1'b1};
            PH_RISE: d = '{scl_low: 1'b0, sda_low: 1'b1};
            PH_HIGH: d = '{scl_low: 1'b0, sda_low: 1'b1};
            default: d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic phase_timed(input stop_phase_e ph,
                                         input logic scl_hi,
                                         input logic sda_hi);
        case (ph)
            PH_HOLD: return 1'b1;
            PH_HIGH: return scl_hi;
            PH_FREE: return sda_hi;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_stop_sync.sv
module i2c_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sr[0] <= 1'b1;
                    else     sr[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sr[s] <= 1'b1;
                    else     sr[s] <= sr[s-1];
                end
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/i2c_stop_timer.sv
module i2c_stop_timer #(
    parameter int TICKS_PER_PHASE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_PHASE - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (done)    cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
    import i2c_stop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic abort,
    input  logic scl_hi,
    input  logic sda_hi,
    input  logic phase_done,
    output logic phase_run,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic stop_seen,
    output logic irq
);
    stop_phase_e ph, ph_nx;
    logic        finish;
    line_drive_t drv;

    always_comb begin
        ph_nx  = ph;
        finish = 1'b0;
        case (ph)
            PH_IDLE: if (stop_req) ph_nx = PH_HOLD;
            PH_HOLD: if (phase_done) ph_nx = PH_RISE;
            PH_RISE: if (scl_hi) ph_nx = PH_HIGH;
            PH_HIGH: begin
                if (!scl_hi)         ph_nx = PH_RISE;
                else if (phase_done) ph_nx = PH_FREE;
            end
            PH_FREE: if (phase_done) begin
                ph_nx  = PH_IDLE;
                finish = 1'b1;
            end
            default: ph_nx = PH_IDLE;
        endcase
        if (abort && ph != PH_IDLE) begin
            ph_nx  = PH_IDLE;
            finish = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            irq       <= 1'b0;
            stop_seen <= 1'b0;
        end else begin
            ph  <= ph_nx;
            irq <= finish;
            if (finish)                        stop_seen <= 1'b1;
            else if (ph == PH_IDLE && stop_req) stop_seen <= 1'b0;
        end
    end

    assign phase_run = phase_timed(ph, scl_hi, sda_hi);
    assign drv       = phase_drive(ph);
    assign scl_oe    = drv.scl_low;
    assign sda_oe    = drv.sda_low;
    assign busy      = (ph != PH_IDLE);

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && stop_req) |=> (busy && scl_oe && sda_oe && !stop_seen)); // R2
    AST_SDA_LOW_AT_SCL_RISE: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_oe) && busy) |-> sda_oe); // R3
    AST_SDA_RISE_AFTER_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_oe) && busy) |-> $past(scl_hi)); // R5
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(busy) && stop_seen)); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !irq && !scl_oe && !sda_oe)); // R7
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && stop_req && !abort && !phase_done) |=> busy); // R8
endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen #(
    parameter int TICKS_PER_PHASE = 1,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic baud_tick,
    input  logic abort,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic stop_seen,
    output logic irq
);
    logic scl_hi, sda_hi, phase_run, phase_done;

    i2c_stop_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_hi)
    );

    i2c_stop_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_hi)
    );

    i2c_stop_timer #(.TICKS_PER_PHASE(TICKS_PER_PHASE)) u_timer (
        .clk(clk), .rst(rst), .run(phase_run), .tick(baud_tick), .done(phase_done)
    );

    i2c_stop_fsm u_fsm (
        .clk(clk), .rst(rst), .stop_req(stop_req), .abort(abort),
        .scl_hi(scl_hi), .sda_hi(sda_hi), .phase_done(phase_done),
        .phase_run(phase_run), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .stop_seen(stop_seen), .irq(irq)
    );
endmodule

// File: tb/i2c_stop_gen_tb.sv
module i2c_stop_gen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b0, baud_tick = 1'b0, abort = 1'b0, hold_scl = 1'b0;
    logic scl_in, sda_in, scl_oe, sda_oe, busy, stop_seen, irq;
    int   total = 0, bad = 0;

    always #10 clk = ~clk;

    assign scl_in = ~scl_oe & ~hold_scl;
    assign sda_in = ~sda_oe;

    i2c_stop_gen dut_i (
        .clk(clk), .rst(rst), .stop_req(stop_req), .baud_tick(baud_tick),
        .abort(abort), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .busy(busy), .stop_seen(stop_seen), .irq(irq)
    );

    // step: 0 idle, 1 both low, 2 SCL released, 3 SDA released
    function automatic logic [4:0] expect_pins(input int step, input logic seen, input logic ir);
        logic [2:0] ln;
        case (step)
            1:       ln = 3'b111;
            2:       ln = 3'b011;
            3:       ln = 3'b001;
            default: ln = 3'b000;
        endcase
        return {ln, seen, ir};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {scl_oe, sda_oe, busy, stop_seen, irq};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req;
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic pulse_tick;
        baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0;
    endtask

    task automatic pulse_abort;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
    endtask

    task automatic run_stop(input int gap, input int stretch, input logic extra_req);
        pulse_req;
        check("R2", expect_pins(1, 1'b0, 1'b0));
        if (extra_req) begin
            pulse_req;
            check("R8", expect_pins(1, 1'b0, 1'b0));
        end
        wait_cyc(gap);
        check("R3", expect_pins(1, 1'b0, 1'b0));
        if (stretch > 0) hold_scl = 1'b1;
        pulse_tick;
        check("R3", expect_pins(2, 1'b0, 1'b0));
        for (int i = 0; i < stretch; i++) begin
            pulse_tick;
            check("R4", expect_pins(2, 1'b0, 1'b0));
        end
        hold_scl = 1'b0;
        pulse_tick;   // SCL level not yet through the synchroniser
        check("R9", expect_pins(2, 1'b0, 1'b0));
        wait_cyc(3);
        check("R4", expect_pins(2, 1'b0, 1'b0));
        pulse_tick;
        check("R5", expect_pins(3, 1'b0, 1'b0));
        pulse_tick;   // SDA level not yet through the synchroniser
        check("R9", expect_pins(3, 1'b0, 1'b0));
        wait_cyc(2);
        check("R5", expect_pins(3, 1'b0, 1'b0));
        pulse_tick;
        check("R6", expect_pins(0, 1'b1, 1'b1));
        wait_cyc(1);
        check("R6", expect_pins(0, 1'b1, 1'b0));
    endtask

    task automatic run_abort(input int ticks);
        pulse_req;
        for (int i = 0; i < ticks; i++) begin
            wait_cyc(1);
            pulse_tick;
        end
        pulse_abort;
        check("R7", expect_pins(0, 1'b0, 1'b0));
        wait_cyc(2);
        check("R7", expect_pins(0, 1'b0, 1'b0));
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_cyc(3);
        rst = 1'b0;
        check("R1", expect_pins(0, 1'b0, 1'b0));

        run_stop(0, 0, 1'b0);
        pulse_abort;
        check("R8", expect_pins(0, 1'b1, 1'b0));
        run_stop(3, 2, 1'b1);
        run_abort(0);
        run_abort(2);

        for (int it = 0; it < 16; it++) begin
            if (it % 4 == 3) run_abort(int'($urandom_range(0, 2)));
            else run_stop(int'($urandom_range(0, 5)), int'($urandom_range(0, 4)),
                          (it % 3) == 0);
            wait_cyc(int'($urandom_range(0, 3)));
        end

        pulse_req;
        pulse_tick;
        rst = 1'b1;
        wait_cyc(1);
        rst = 1'b0;
        check("R1", expect_pins(0, 1'b0, 1'b0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule